// File: doc/BRIEF.md
# Dual-Clock Activity Monitor with Failover

This block watches an internal and an external clock source and decides, from the system clock domain, whether each is still toggling. Each source is brought into the system domain through a short synchronizer chain and reduced to a one-cycle rising-edge pulse. The edges of each source are counted against a window of edges taken from the other source. If a full window passes with no edge from the watched source, that source is declared lost. On a loss the block latches a fault flag and can raise an interrupt. It also moves the clock select to the source that is still running. That select drives both the main clock output and the timebase clock output.

Software controls the block through one small register. Reads return the register contents one cycle after the read strobe. The monitor can be switched on only while both sources report stable. Once on, it stays on until software switches it off. The fault flag clears only when a read that sees it set is followed later by a write of zero to it. A configuration input says whether the external source is slow. When it is slow, the window used to judge the external source is stretched by a parameter factor.

Top module: `ckmon_top`

## Requirements
- R1: After reset, every register bit reads 0: monitor off, flag clear, interrupt enable off, and select = 0 (internal source). `irq` and `clk_sel` are low.
- R2: A write with bit 0 = 1 turns the monitor on only when `int_stable` and `ext_stable` are both high in that cycle. Otherwise that write leaves bit 0 unchanged. A write with bit 0 = 0 always turns the monitor off.
- R3: Once the monitor is on, it stays on when either stable input later goes low.
- R4: The flag (bit 1) clears only on a write with bit 1 = 0 that follows a read in which the flag read as 1. A write of 0 with no such earlier read leaves the flag set.
- R5: A write with bit 1 = 1 never changes the flag.
- R6: With the monitor on, loss of the internal source sets the flag and sets select (bit 3) to 1 (external). Loss of the external source sets the flag and sets select to 0 (internal). `main_clk` and `tbase_clk` then follow the surviving source.
- R7: While both sources run at the same period of 8 system cycles, the monitor reports no loss, with `ext_slow` either 0 or 1.
- R8: `irq` equals the flag ANDed with the interrupt enable (bit 2). It falls in the same cycle that the clearing write takes effect.
- R9: `ext_slow` = 1 stretches the window for the external source by `SLOW_SCALE`. An external period of 8 internal periods, with `WIN_EDGES` = 4, is judged lost when `ext_slow` = 0 and healthy when `ext_slow` = 1.
- R10: While the monitor is off, no loss is detected and the select changes only through writes. Turning the monitor off clears the detection counters and keeps the select value.
- R11: A write to select (bit 3) takes effect only while the monitor is off. While the monitor is on, the written value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for registers and detection |
| rst | input | 1 | Synchronous active-high reset |
| int_clk | input | 1 | Internal clock source being watched |
| ext_clk | input | 1 | External clock source being watched |
| int_stable | input | 1 | Internal source reports stable |
| ext_stable | input | 1 | External source reports stable |
| ext_slow | input | 1 | External source is slow; stretches its window |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data: bit 0 monitor on, bit 1 flag, bit 2 interrupt enable, bit 3 select |
| reg_rdata | output | 6 | Registered read data: bits 3..0 as written, bit 4 int_stable, bit 5 ext_stable |
| irq | output | 1 | Monitor interrupt |
| clk_sel | output | 1 | Current source: 0 internal, 1 external |
| main_clk | output | 1 | Selected main clock |
| tbase_clk | output | 1 | Selected timebase clock |

## Verification
The assertions assume that the stable inputs, the slow setting and the register strobes are already synchronous to the system clock. They also assume that each watched source, while running, toggles much more slowly than the system clock. Without that, a synchronized edge could be missed and a loss might never be decided. The stimulus keeps within these limits. It drives every control input on the falling system edge, and it runs both sources with half-periods of at least four system cycles. A stopped source is held at a constant level, so a loss is always a clean absence of edges.

// File: rtl/ckmon_pkg.sv
package ckmon_pkg;
  localparam int WR_W = 4;
  localparam int RD_W = 6;
  localparam int B_EN   = 0;
  localparam int B_FLAG = 1;
  localparam int B_IEN  = 2;
  localparam int B_SEL  = 3;
  localparam int B_IST  = 4;
  localparam int B_EST  = 5;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
endpackage

// File: rtl/ckmon_edge_det.sv
module ckmon_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
      edge_o <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
      edge_o <= chain[STAGES-1] & ~last_q;
    end
  end
endmodule

// File: rtl/ckmon_watch.sv
module ckmon_watch #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             ref_edge,
  input  logic             mon_edge,
  input  logic [CNT_W-1:0] win_len,
  output logic             lost_o
);
  logic [CNT_W-1:0] ref_cnt;
  logic             seen;
  logic             win_end;

  assign win_end = (ref_cnt == win_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ref_cnt <= '0;
      seen    <= 1'b0;
      lost_o  <= 1'b0;
    end else begin
      lost_o <= 1'b0;
      if (mon_edge) seen <= 1'b1;
      if (ref_edge) begin
        if (win_end) begin
          ref_cnt <= '0;
          seen    <= 1'b0;
          lost_o  <= ~seen & ~mon_edge;
        end else begin
          ref_cnt <= ref_cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ckmon_top.sv
module ckmon_top
  import ckmon_pkg::*;
#(
  parameter int WIN_EDGES   = 4,
  parameter int SLOW_SCALE  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            int_clk,
  input  logic            ext_clk,
  input  logic            int_stable,
  input  logic            ext_stable,
  input  logic            ext_slow,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [WR_W-1:0] reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            irq,
  output logic            clk_sel,
  output logic            main_clk,
  output logic            tbase_clk
);
  localparam int LONG_WIN = WIN_EDGES * SLOW_SCALE;
  localparam int CNT_W    = $clog2(LONG_WIN + 1);

  logic       mon_en, flag, ien, armed;
  src_e       sel;
  logic       en_n, flag_n, ien_n, armed_n;
  src_e       sel_n;
  logic [1:0] src_raw, edge_v, lost_v;
  logic [CNT_W-1:0] win_v [2];
  logic       lost_int, lost_ext, sel_clk;

  assign src_raw  = {ext_clk, int_clk};
  assign win_v[0] = CNT_W'(WIN_EDGES);
  assign win_v[1] = ext_slow ? CNT_W'(LONG_WIN) : CNT_W'(WIN_EDGES);

  // index 0 watches the internal source, index 1 the external one
  for (genvar g = 0; g < 2; g++) begin : g_src
    ckmon_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .async_in(src_raw[g]), .edge_o(edge_v[g])
    );
    ckmon_watch #(.CNT_W(CNT_W)) u_watch (
      .clk(clk), .rst(rst), .clear(~mon_en),
      .ref_edge(edge_v[1-g]), .mon_edge(edge_v[g]),
      .win_len(win_v[g]), .lost_o(lost_v[g])
    );
  end

  assign lost_int = lost_v[0];
  assign lost_ext = lost_v[1];

  always_comb begin
    en_n    = mon_en;
    flag_n  = flag;
    ien_n   = ien;
    sel_n   = sel;
    armed_n = armed;
    if (reg_wr) begin
      ien_n = reg_wdata[B_IEN];
      if (!reg_wdata[B_EN])             en_n = 1'b0;
      else if (int_stable && ext_stable) en_n = 1'b1;
      if (!mon_en) sel_n = src_e'(reg_wdata[B_SEL]);
      if (armed && !reg_wdata[B_FLAG]) begin
        flag_n  = 1'b0;
        armed_n = 1'b0;
      end
    end
    if (mon_en && lost_int) begin
      flag_n = 1'b1;
      sel_n  = SRC_EXT;
    end else if (mon_en && lost_ext) begin
      flag_n = 1'b1;
      sel_n  = SRC_INT;
    end
    if (reg_rd && flag && flag_n) armed_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_en    <= 1'b0;
      flag      <= 1'b0;
      ien       <= 1'b0;
      sel       <= SRC_INT;
      armed     <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      mon_en <= en_n;
      flag   <= flag_n;
      ien    <= ien_n;
      sel    <= sel_n;
      armed  <= armed_n;
      irq    <= flag_n & ien_n;
      if (reg_rd)
        reg_rdata <= {ext_stable, int_stable, sel, ien, flag, mon_en};
    end
  end

  assign clk_sel   = sel;
  assign sel_clk   = (sel == SRC_EXT) ? ext_clk : int_clk;
  assign main_clk  = sel_clk;
  assign tbase_clk = sel_clk;
endmodule

// File: rtl/ckmon_checker.sv
module ckmon_checker (
  input logic clk,
  input logic rst,
  input logic int_stable,
  input logic ext_stable,
  input logic reg_wr,
  input logic wd_en,
  input logic wd_flag,
  input logic mon_en,
  input logic flag,
  input logic ien,
  input logic sel,
  input logic irq,
  input logic lost_int,
  input logic lost_ext
);
  assert_en_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mon_en) |-> $past(reg_wr && wd_en && int_stable && ext_stable));

  assert_en_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    mon_en && !(reg_wr && !wd_en) |=> mon_en);

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(reg_wr && !wd_flag));

  assert_flag_w1_R5: assert property (@(posedge clk) disable iff (rst)
    flag && !(reg_wr && !wd_flag) |=> flag);

  assert_int_lost_sel_R6: assert property (@(posedge clk) disable iff (rst)
    mon_en && lost_int |=> sel);

  assert_ext_lost_sel_R6: assert property (@(posedge clk) disable iff (rst)
    mon_en && lost_ext && !lost_int |=> !sel);

  assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ien));

  assert_sel_off_R10: assert property (@(posedge clk) disable iff (rst)
    !mon_en && !reg_wr |=> $stable(sel));

  assert_sel_on_R11: assert property (@(posedge clk) disable iff (rst)
    mon_en && !lost_int && !lost_ext |=> $stable(sel));
endmodule

bind ckmon_top ckmon_checker u_chk (
  .clk(clk), .rst(rst), .int_stable(int_stable), .ext_stable(ext_stable),
  .reg_wr(reg_wr), .wd_en(reg_wdata[0]), .wd_flag(reg_wdata[1]),
  .mon_en(mon_en), .flag(flag), .ien(ien), .sel(sel), .irq(irq),
  .lost_int(lost_int), .lost_ext(lost_ext)
);

// File: tb/ckmon_top_bench.sv
`timescale 1ns/1ps
module ckmon_top_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic int_clk = 1'b0, ext_clk = 1'b0;
  logic int_stable = 1'b0, ext_stable = 1'b0, ext_slow = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic irq, clk_sel, main_clk, tbase_clk;

  int checks = 0, errors = 0;
  int int_half = 40, ext_half = 40;
  bit int_run = 1'b1, ext_run = 1'b1;

  ckmon_top u_ckmon_top (
    .clk(clk), .rst(rst), .int_clk(int_clk), .ext_clk(ext_clk),
    .int_stable(int_stable), .ext_stable(ext_stable), .ext_slow(ext_slow),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .clk_sel(clk_sel),
    .main_clk(main_clk), .tbase_clk(tbase_clk)
  );

  always #5 clk = ~clk;
  initial forever begin
    #(int_half);
    if (int_run) int_clk = ~int_clk;
  end
  initial forever begin
    #(ext_half);
    if (ext_run) ext_clk = ~ext_clk;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; reg_rd = 1'b0; reg_wr = 1'b0;
    wait_clk(5);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [5:0] d);
    @(negedge clk);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  logic [5:0] r;

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 irq", int'(irq), 0);
    chk("R1 clk_sel", int'(clk_sel), 0);
    rd(r);
    chk("R1 reg bits", int'(r[3:0]), 0);

    // R2 enable gating, R3 stickiness
    int_stable = 1'b0; ext_stable = 1'b1;
    wr(4'h1); rd(r); chk("R2 int unstable", int'(r[0]), 0);
    int_stable = 1'b1; ext_stable = 1'b0;
    wr(4'h1); rd(r); chk("R2 ext unstable", int'(r[0]), 0);
    ext_stable = 1'b1;
    wr(4'h1); rd(r); chk("R2 both stable", int'(r[0]), 1);
    int_stable = 1'b0;
    wait_clk(3); rd(r); chk("R3 int drop", int'(r[0]), 1);
    ext_stable = 1'b0;
    wait_clk(3); rd(r); chk("R3 ext drop", int'(r[0]), 1);
    wr(4'h0); rd(r); chk("R2 disable", int'(r[0]), 0);

    // R11 select writes
    int_stable = 1'b1; ext_stable = 1'b1;
    wr(4'h8); rd(r); chk("R11 sel write off", int'(r[3]), 1);
    wr(4'h9); wr(4'h1); rd(r); chk("R11 sel write on ignored", int'(r[3]), 1);
    chk("R11 clk_sel port", int'(clk_sel), 1);

    // Sweep: slow setting x lost source x interrupt enable
    for (int slow = 0; slow < 2; slow++) begin
      for (int lost = 0; lost < 2; lost++) begin
        for (int ie = 0; ie < 2; ie++) begin
          logic [3:0] ienb;
          int exp_sel;
          ienb = ie[0] ? 4'h4 : 4'h0;
          exp_sel = (lost == 0) ? 1 : 0;
          int_run = 1'b1; ext_run = 1'b1;
          int_half = 40; ext_half = 40;
          ext_slow = slow[0];
          int_stable = 1'b1; ext_stable = 1'b1;
          do_reset();
          wr(ienb | 4'h1);
          wait_clk(300);
          chk("R7 no false loss", int'(irq), 0);
          rd(r);
          chk("R7 flag clear while running", int'(r[1]), 0);
          chk("R7 sel unchanged", int'(r[3]), 0);
          if (lost == 0) int_run = 1'b0; else ext_run = 1'b0;
          wait_clk(300);
          chk("R6 clk_sel to survivor", int'(clk_sel), exp_sel);
          chk("R8 irq on loss", int'(irq), ie);
          for (int k = 0; k < 4; k++) begin
            wait_clk(3);
            chk("R6 main_clk follows", int'(main_clk),
                int'(lost == 0 ? ext_clk : int_clk));
            chk("R6 tbase_clk follows", int'(tbase_clk),
                int'(lost == 0 ? ext_clk : int_clk));
          end
          // write 0 without prior read, also turn monitor off
          wr(ienb | (exp_sel[0] ? 4'h8 : 4'h0));
          rd(r);
          chk("R4 flag kept without read", int'(r[1]), 1);
          chk("R10 monitor off", int'(r[0]), 0);
          chk("R6 sel after loss", int'(r[3]), exp_sel);
          wr(ienb | 4'h2 | (exp_sel[0] ? 4'h8 : 4'h0));
          rd(r);
          chk("R5 write one ignored", int'(r[1]), 1);
          chk("R8 irq still set", int'(irq), ie);
          wr(ienb | (exp_sel[0] ? 4'h8 : 4'h0));
          chk("R8 irq falls with clear", int'(irq), 0);
          rd(r);
          chk("R4 flag cleared after read", int'(r[1]), 0);
          wait_clk(300);
          rd(r);
          chk("R10 no detection while off", int'(r[1]), 0);
          chk("R10 sel kept", int'(r[3]), exp_sel);
        end
      end
    end

    // R9 slow external source: 8 internal periods per external period
    for (int slow = 0; slow < 2; slow++) begin
      int_run = 1'b1; ext_run = 1'b1;
      int_half = 40; ext_half = 320;
      ext_slow = slow[0];
      int_stable = 1'b1; ext_stable = 1'b1;
      do_reset();
      wr(4'h1);
      wait_clk(600);
      rd(r);
      chk("R9 slow ext flag", int'(r[1]), slow == 0 ? 1 : 0);
      chk("R9 slow ext sel", int'(r[3]), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule